// File: doc/BRIEF.md
# Adaptive-Step Digital LDO Loop Controller

This block is the synchronous control loop of a digital low-dropout regulator. On every sample clock it reads a 5-bit code from a row of comparators. The comparators sit at five levels spread around the reference: two below it, one at it and two above it, spaced by a fixed margin. From that code the block grows or shrinks a 128-bit thermometer word that turns on parallel power-switch elements. The loop gain rises with the size of the error. The block also decodes the same code, with no register on the path, into a 3-bit speed request for an external tunable sample oscillator.

A settle detector runs on the free-running clock. It watches the comparator at the reference level while the output stays inside the inner band. After a run of back-to-back sign changes it raises a clock-off indication, which freezes the switch word so the output stops dithering. The word register is the only part whose update is held back. The freeze ends in the same cycle that the output leaves the inner band, for example after a load step or a move of the reference. The comparator code is a plain sample that is taken on every clock, so there is no handshake and no back-pressure.

Top module: `ldo_step_ctrl`

## Requirements
- R1: A synchronous reset (rst high at a rising edge) sets 64 elements on (sw_word = 64 low bits set), clears the settle state, and holds clk_gate_off low.
- R2: sw_word is always a thermometer word: with k elements on, bits k-1..0 are 1 and all higher bits are 0, with 0 <= k <= 128.
- R3: Code bit i is 1 when the output is above threshold i (bit0 at ref-2d, bit1 at ref-d, bit2 at ref, bit3 at ref+d, bit4 at ref+2d). On an ungated edge, the element count changes by +4 for 00000, +2 for 00001, +1 for 00011, -1 for 00111, -2 for 01111 and -4 for 11111.
- R4: The count saturates at 128 when stepping up and at 0 when stepping down, and never wraps.
- R5: osc_fsel depends combinationally on cmp_code: 001 for 00011 or 00111, 011 for 00001 or 01111, 111 for 00000 or 11111.
- R6: Any code that is not one of the six thermometer patterns gives a step of zero and osc_fsel 001. It is neither counted as a reversal nor breaks a run of reversals, and it leaves the settle state unchanged.
- R7: In-band codes are 00011 and 00111, and bit2 is the sign. After 4 consecutive sign reversals among in-band samples, clk_gate_off goes high from the next cycle. While it is high the count does not change.
- R8: An out-of-band code (00000, 00001, 01111, 11111) drives clk_gate_off low in the same cycle. Its step is applied at that edge, and the reversal count restarts from zero.
- R9: An in-band sample with the same sign as the previous in-band sample resets the reversal count. The first in-band sample after reset or after an out-of-band sample only records the sign.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running sample clock |
| rst | input | 1 | Synchronous reset, active high |
| cmp_code | input | 5 | Comparator code, bit i set when output above threshold i |
| sw_word | output | 128 | Thermometer word to the power-switch elements |
| osc_fsel | output | 3 | Thermometer speed request to the sample oscillator |
| clk_gate_off | output | 1 | High while the switch-word clock is held off |

## Verification
Two functions can act in the same cycle: the release of the freeze and the step of the sample that causes it. An out-of-band code that arrives while clk_gate_off is high must drop the flag during that cycle and also move the word at the following edge. The bench provokes this by settling the loop with alternating in-band codes and then applying each of the four out-of-band codes, one of them with the count already at a rail. A behavioural model predicts the flag before the edge and the word after it, and both are compared on every cycle.

// File: rtl/ldo_ctrl_pkg.sv
package ldo_ctrl_pkg;
  typedef enum logic [2:0] {
    ZONE_FAR_LO,
    ZONE_MID_LO,
    ZONE_NEAR_LO,
    ZONE_NEAR_HI,
    ZONE_MID_HI,
    ZONE_FAR_HI,
    ZONE_BAD
  } err_zone_t;

  localparam int FSEL_W = 3;
endpackage

// File: rtl/ldo_err_decode.sv
module ldo_err_decode
  import ldo_ctrl_pkg::*;
#(
  parameter int STEP_NEAR = 1,
  parameter int STEP_MID  = 2,
  parameter int STEP_FAR  = 4,
  parameter int STEP_W    = 3
) (
  input  logic [4:0]        code,
  output logic [STEP_W-1:0] step_mag,
  output logic              step_up,
  output logic [FSEL_W-1:0] fsel,
  output logic              in_band,
  output logic              out_band,
  output logic              sign_hi
);
  err_zone_t zone;

  always_comb begin
    unique case (code)
      5'b00000: zone = ZONE_FAR_LO;
      5'b00001: zone = ZONE_MID_LO;
      5'b00011: zone = ZONE_NEAR_LO;
      5'b00111: zone = ZONE_NEAR_HI;
      5'b01111: zone = ZONE_MID_HI;
      5'b11111: zone = ZONE_FAR_HI;
      default:  zone = ZONE_BAD;
    endcase
  end

  always_comb begin
    step_mag = '0;
    step_up  = 1'b0;
    fsel     = 3'b001;
    unique case (zone)
      ZONE_FAR_LO:  begin step_mag = STEP_W'(STEP_FAR);  step_up = 1'b1; fsel = 3'b111; end
      ZONE_MID_LO:  begin step_mag = STEP_W'(STEP_MID);  step_up = 1'b1; fsel = 3'b011; end
      ZONE_NEAR_LO: begin step_mag = STEP_W'(STEP_NEAR); step_up = 1'b1; end
      ZONE_NEAR_HI: begin step_mag = STEP_W'(STEP_NEAR); end
      ZONE_MID_HI:  begin step_mag = STEP_W'(STEP_MID);  fsel = 3'b011; end
      ZONE_FAR_HI:  begin step_mag = STEP_W'(STEP_FAR);  fsel = 3'b111; end
      default:      ;
    endcase
  end

  assign in_band  = (zone == ZONE_NEAR_LO) || (zone == ZONE_NEAR_HI);
  assign out_band = (zone != ZONE_BAD) && !in_band;
  assign sign_hi  = code[2];

  // fsel must always be a thermometer request (R5)
  always_comb begin
    assert_fsel_thermo_R5: assert (fsel == 3'b001 || fsel == 3'b011 || fsel == 3'b111);
  end
endmodule

// File: rtl/ldo_settle_det.sv
module ldo_settle_det #(
  parameter int SETTLE_REV = 4,
  localparam int REV_W = $clog2(SETTLE_REV + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic in_band,
  input  logic out_band,
  input  logic sign_hi,
  output logic gate
);
  logic             gated_q;
  logic [REV_W-1:0] rev_q;
  logic             have_sign_q;
  logic             last_sign_q;
  logic             reversal;

  assign reversal = in_band && have_sign_q && (sign_hi != last_sign_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      gated_q     <= 1'b0;
      rev_q       <= '0;
      have_sign_q <= 1'b0;
      last_sign_q <= 1'b0;
    end else if (out_band) begin
      gated_q     <= 1'b0;
      rev_q       <= '0;
      have_sign_q <= 1'b0;
    end else if (in_band) begin
      have_sign_q <= 1'b1;
      last_sign_q <= sign_hi;
      if (reversal) begin
        if (rev_q == REV_W'(SETTLE_REV - 1)) gated_q <= 1'b1;
        if (rev_q < REV_W'(SETTLE_REV)) rev_q <= rev_q + 1'b1;
      end else begin
        rev_q <= '0;
      end
    end
  end

  assign gate = gated_q && !out_band;

  // Freeze only rises on the reversal that completes the run (R7)
  assert_settle_after_run_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(gated_q) |-> ($past(rev_q) == REV_W'(SETTLE_REV - 1)));

  // Leaving the band clears freeze and reversal count (R8)
  assert_release_clears_R8: assert property (@(posedge clk) disable iff (rst)
    out_band |=> (!gated_q && rev_q == '0));
endmodule

// File: rtl/ldo_switch_reg.sv
module ldo_switch_reg #(
  parameter int N_SW      = 128,
  parameter int STEP_W    = 3,
  parameter int MAX_STEP  = 4,
  parameter int RST_LEVEL = 64,
  localparam int CNT_W = $clog2(N_SW + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              step_up,
  input  logic [STEP_W-1:0] step_mag,
  output logic [N_SW-1:0]   word
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   sum_up;
  logic [CNT_W-1:0] cnt_next;
  logic [CNT_W-1:0] step_ext;

  assign step_ext = CNT_W'(step_mag);
  assign sum_up   = {1'b0, cnt_q} + {1'b0, step_ext};

  always_comb begin
    if (step_up) begin
      cnt_next = (sum_up > (CNT_W + 1)'(N_SW)) ? CNT_W'(N_SW) : sum_up[CNT_W-1:0];
    end else begin
      cnt_next = (cnt_q < step_ext) ? '0 : cnt_q - step_ext;
    end
  end

  // enable stands in for the integrated clock gate on this register only
  always_ff @(posedge clk) begin
    if (rst) cnt_q <= CNT_W'(RST_LEVEL);
    else if (en) cnt_q <= cnt_next;
  end

  for (genvar i = 0; i < N_SW; i++) begin : g_therm
    assign word[i] = (cnt_q > CNT_W'(i));
  end

  // Count never exceeds the element total (R4)
  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CNT_W'(N_SW));

  // Frozen while the clock is held off (R7)
  assert_hold_when_gated_R7: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(cnt_q));

  // A single edge never moves more than the largest step (R3)
  assert_step_bound_R3: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((32'(cnt_q) <= 32'($past(cnt_q)) + MAX_STEP) &&
              (32'($past(cnt_q)) <= 32'(cnt_q) + MAX_STEP)));
endmodule

// File: rtl/ldo_step_ctrl.sv
module ldo_step_ctrl
  import ldo_ctrl_pkg::*;
#(
  parameter int N_SW       = 128,
  parameter int STEP_NEAR  = 1,
  parameter int STEP_MID   = 2,
  parameter int STEP_FAR   = 4,
  parameter int SETTLE_REV = 4,
  localparam int STEP_W    = $clog2(STEP_FAR + 1),
  localparam int RST_LEVEL = N_SW / 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [4:0]        cmp_code,
  output logic [N_SW-1:0]   sw_word,
  output logic [FSEL_W-1:0] osc_fsel,
  output logic              clk_gate_off
);
  logic [STEP_W-1:0] step_mag;
  logic              step_up;
  logic              in_band;
  logic              out_band;
  logic              sign_hi;

  ldo_err_decode #(
    .STEP_NEAR(STEP_NEAR), .STEP_MID(STEP_MID), .STEP_FAR(STEP_FAR), .STEP_W(STEP_W)
  ) u_decode (
    .code(cmp_code), .step_mag(step_mag), .step_up(step_up), .fsel(osc_fsel),
    .in_band(in_band), .out_band(out_band), .sign_hi(sign_hi)
  );

  ldo_settle_det #(.SETTLE_REV(SETTLE_REV)) u_settle (
    .clk(clk), .rst(rst), .in_band(in_band), .out_band(out_band),
    .sign_hi(sign_hi), .gate(clk_gate_off)
  );

  ldo_switch_reg #(
    .N_SW(N_SW), .STEP_W(STEP_W), .MAX_STEP(STEP_FAR), .RST_LEVEL(RST_LEVEL)
  ) u_switch (
    .clk(clk), .rst(rst), .en(!clk_gate_off), .step_up(step_up),
    .step_mag(step_mag), .word(sw_word)
  );

  // Out-of-band sample never sees the freeze (R8)
  assert_release_same_cycle_R8: assert property (@(posedge clk) disable iff (rst)
    (osc_fsel != 3'b001) |-> !clk_gate_off);
endmodule

// File: tb/ldo_step_ctrl_tb.sv
module ldo_step_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NSW = 128;
  localparam logic [4:0] C_FL = 5'b00000, C_ML = 5'b00001, C_NL = 5'b00011,
                         C_NH = 5'b00111, C_MH = 5'b01111, C_FH = 5'b11111;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic [4:0]     cmp_code = C_NL;
  logic [NSW-1:0] sw_word;
  logic [2:0]     osc_fsel;
  logic           clk_gate_off;

  int checks = 0;
  int errors = 0;

  int m_cnt = 64;
  int m_rev = 0;
  bit m_gated = 0;
  bit m_have = 0;
  bit m_sign = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ldo_step_ctrl dut_i (
    .clk(clk), .rst(rst), .cmp_code(cmp_code), .sw_word(sw_word),
    .osc_fsel(osc_fsel), .clk_gate_off(clk_gate_off)
  );

  function automatic logic [NSW-1:0] therm(int k);
    logic [NSW-1:0] w = '0;
    for (int i = 0; i < k; i++) w[i] = 1'b1;
    return w;
  endfunction

  function automatic int delta_of(logic [4:0] c);
    case (c)
      C_FL: return 4;  C_ML: return 2;  C_NL: return 1;
      C_NH: return -1; C_MH: return -2; C_FH: return -4;
      default: return 0;
    endcase
  endfunction

  function automatic logic [2:0] fsel_of(logic [4:0] c);
    case (c)
      C_FL, C_FH: return 3'b111;
      C_ML, C_MH: return 3'b011;
      default:    return 3'b001;
    endcase
  endfunction

  function automatic bit is_out(logic [4:0] c);
    return (c == C_FL) || (c == C_ML) || (c == C_MH) || (c == C_FH);
  endfunction

  function automatic bit is_in(logic [4:0] c);
    return (c == C_NL) || (c == C_NH);
  endfunction

  task automatic check_bit(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_vec(string req, logic [NSW-1:0] act, logic [NSW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // one sample: drive, check combinational outputs, advance model, check word
  task automatic apply(logic [4:0] c);
    bit gate_now;
    string wreq;
    @(negedge clk);
    cmp_code = c;
    #1;
    gate_now = m_gated && !is_out(c);
    checks++;
    if (osc_fsel !== fsel_of(c)) begin
      errors++;
      $display("FAIL %s: fsel got %b expected %b code %b", is_in(c) || is_out(c) ? "R5" : "R6",
               osc_fsel, fsel_of(c), c);
    end
    check_bit(is_out(c) ? "R8" : "R7", clk_gate_off, gate_now);
    wreq = gate_now ? "R7" : (delta_of(c) == 0 ? "R6" : "R3");
    if (!gate_now) begin
      m_cnt += delta_of(c);
      if (m_cnt > NSW) begin m_cnt = NSW; wreq = "R4"; end
      if (m_cnt < 0)   begin m_cnt = 0;   wreq = "R4"; end
    end
    if (is_out(c)) begin
      m_gated = 0; m_rev = 0; m_have = 0;
    end else if (is_in(c)) begin
      if (m_have && (c[2] != m_sign)) begin
        m_rev++;
        if (m_rev == 4) m_gated = 1;
      end else begin
        m_rev = 0;
      end
      m_have = 1; m_sign = c[2];
    end
    @(posedge clk);
    #1;
    check_vec(wreq, sw_word, therm(m_cnt));
    check_vec("R2", sw_word & ~therm(m_cnt), '0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    #1;
    rst = 1'b0;
    m_cnt = 64; m_rev = 0; m_gated = 0; m_have = 0; m_sign = 0;
    check_vec("R1", sw_word, therm(64));
    check_bit("R1", clk_gate_off, 1'b0);
  endtask

  task automatic dither(int n);
    for (int i = 0; i < n; i++) apply(i % 2 == 0 ? C_NL : C_NH);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : stim
    logic [7:0] lfsr = 8'hA5;
    logic [4:0] pool [8] = '{C_FL, C_ML, C_NL, C_NH, C_MH, C_FH, 5'b10101, 5'b00010};
    do_reset();
    // R3 each zone, R5 fsel
    apply(C_ML); apply(C_MH); apply(C_NL); apply(C_NH); apply(C_FL); apply(C_FH);
    // R4 upper rail
    for (int i = 0; i < 20; i++) apply(C_FL);
    apply(C_ML);
    // R4 lower rail
    for (int i = 0; i < 36; i++) apply(C_FH);
    apply(C_MH); apply(C_NH);
    // R6 invalid codes
    apply(5'b10000); apply(5'b01010); apply(5'b11011);
    for (int i = 0; i < 4; i++) apply(C_FL);
    // R7 settle then freeze; R8 release with step at same edge
    dither(5);
    dither(6);
    apply(C_ML);
    // R9 same-sign breaks the run
    apply(C_NL); apply(C_NH); apply(C_NL); apply(C_NL); apply(C_NH); apply(C_NL); apply(C_NH);
    apply(C_NL);
    apply(C_FH);
    // R6 invalid interleaved does not break run
    apply(C_NL); apply(C_NH); apply(5'b10001); apply(C_NL); apply(C_NH); apply(C_NL);
    apply(C_NH); apply(C_MH);
    // R8 release at a rail while gated
    for (int i = 0; i < 40; i++) apply(C_FL);
    dither(6);
    apply(C_FL);
    dither(6);
    apply(C_FH);
    dither(6);
    apply(C_MH);
    // pseudo-random mix
    for (int i = 0; i < 600; i++) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      if (lfsr[7:6] == 2'b00) apply(pool[lfsr[2:0]]);
      else apply(lfsr[0] ? C_NL : C_NH);
    end
    // R1 reset mid-run
    dither(6);
    do_reset();
    apply(C_NL);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule